// File: doc/BRIEF.md
# Descriptor-Chain DMA Channel Sequencer

This block drives one DMA channel through a chain of descriptors held in memory. Software places a pointer to the first descriptor on the control inputs and pulses the start input. The block then reads the four words of that descriptor over a word-wide fetch port, one handshake per word. Next it copies the requested number of bytes in bursts over a second memory port. Each burst is read into a small local buffer and then written back out. Source and target addresses advance as the command word selects.

A descriptor occupies 16 aligned bytes. Its words, in fetch order, are the link, the source address, the target address and the command. The link gives the next descriptor address and a stop mark. When the last burst of a descriptor has been written, the channel either halts (stop mark set) or fetches the descriptor the link points to. Status outputs report a halted state and three sticky flags: end, start and bus error. All three flags are cleared by the next start.

The controller moves through these states. IDLE is the halted state. FETCH reads the four words. DECODE loads the counters from the command. PACE waits for the peripheral request where pacing is on. READ fills the burst buffer and WRITE drains it. RETIRE closes a descriptor. The transitions are:
- IDLE to FETCH on start.
- FETCH to DECODE after the fourth word.
- DECODE to RETIRE for a zero length, otherwise to PACE.
- PACE to READ when the burst may begin.
- READ to WRITE after the last read beat of a burst.
- WRITE to PACE if bytes remain, otherwise to RETIRE.
- RETIRE to FETCH to follow the link, or to IDLE on a stop mark.
- Any state to IDLE on a bus error or a halt request.

Top module: `dchain_seq`

## Requirements
- R1: After reset the channel is halted (`sts_halted`=1), all three flags read 0, and neither port requests.
- R2: A start reads four words, in this order: descriptor address +0 (link), +4 (source), +8 (target) and +12 (command). The descriptor address is the start pointer with bits 3:0 forced to zero.
- R3: The channel copies exactly the byte count in command bits 12:0. Command bit 31 advances the source address by each beat's byte count, and bit 30 does the same for the target; a clear bit keeps that address fixed.
- R4: Command bits 17:16 set the burst size: 1 is 8 bytes, 2 is 16 bytes, 3 is 32 bytes, and 0 acts as 8 bytes. All read beats of a burst complete before its first write beat. A final burst shorter than the burst size carries only the bytes that remain.
- R5: Command bits 15:14 set the beat width: 1 is 1 byte, 2 is 2 bytes, 3 is 4 bytes, and 0 acts as 4 bytes. `mem_bytes` carries the width, or fewer bytes if fewer remain in the burst. No byte beyond the length is written.
- R6: When a descriptor completes, link bit 0 set halts the channel. Otherwise the next descriptor is fetched from link bits 31:4 with four zero bits appended.
- R7: A descriptor with length 0 makes no data access and moves straight to its link.
- R8: `sts_end` is set when a descriptor with command bit 21 completes, and it is not set by descriptors without that bit.
- R9: `sts_start` is set when a descriptor with command bit 22 has been fetched.
- R10: If command bit 29 or bit 28 is set, a burst begins only while `dev_req` is 1. If both bits are clear, `dev_req` is ignored.
- R11: A pulse on `ctl_halt` stops the channel at the next handshake or state boundary. No further request is made and `sts_halted` reads 1.
- R12: An error on a fetch or data handshake sets `sts_buserr` and halts the channel without following the link.
- R13: A start clears `sts_end`, `sts_start` and `sts_buserr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_go | input | 1 | Start pulse, taken while halted |
| ctl_desc_ptr | input | 32 | First descriptor address |
| ctl_halt | input | 1 | Halt request pulse |
| dev_req | input | 1 | Peripheral request for paced transfers |
| dsc_req | output | 1 | Descriptor word read request |
| dsc_addr | output | 32 | Descriptor word address |
| dsc_ack | input | 1 | Descriptor read completes this cycle |
| dsc_err | input | 1 | Error on the acknowledged fetch |
| dsc_rdata | input | 32 | Descriptor word |
| mem_req | output | 1 | Data beat request |
| mem_we | output | 1 | 1 for a write beat, 0 for a read beat |
| mem_addr | output | 32 | Data beat byte address |
| mem_bytes | output | 3 | Bytes in this beat, 1 to 4, in the low lanes |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Data beat completes this cycle |
| mem_err | input | 1 | Error on the acknowledged beat |
| mem_rdata | input | 32 | Read data |
| sts_halted | output | 1 | Channel is halted |
| sts_end | output | 1 | Sticky end flag |
| sts_start | output | 1 | Sticky start flag |
| sts_buserr | output | 1 | Sticky bus-error flag |

## Verification
The assertions rely on the memory side following the handshakes. An acknowledge comes only in a cycle where the matching request is high, and an error is raised only together with an acknowledge. Descriptor pointers are assumed to be 16-byte aligned, and lengths to fit the 13-bit field. The bench's memory model answers every request one cycle after it appears. It raises an error only on an acknowledged access to a single chosen address, and every descriptor it builds sits on a 16-byte boundary.

// File: rtl/dchain_pkg.sv
package dchain_pkg;

    localparam int WORD_W  = 32;
    localparam int LEN_W   = 13;
    localparam int BURST_W = 6;
    localparam int BEAT_W  = 3;

    localparam int CB_SRC_INC   = 31;
    localparam int CB_DST_INC   = 30;
    localparam int CB_PACE_SRC  = 29;
    localparam int CB_PACE_DST  = 28;
    localparam int CB_IRQ_START = 22;
    localparam int CB_IRQ_END   = 21;
    localparam int CB_BURST_LO  = 16;
    localparam int CB_WIDTH_LO  = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_PACE,
        ST_READ,
        ST_WRITE,
        ST_RETIRE
    } dc_state_e;

    typedef struct packed {
        logic               src_inc;
        logic               dst_inc;
        logic               paced;
        logic               irq_start;
        logic               irq_end;
        logic [BURST_W-1:0] burst_bytes;
        logic [BEAT_W-1:0]  width_bytes;
        logic [LEN_W-1:0]   len;
    } dc_cmd_t;

endpackage

// File: rtl/dchain_cmd_dec.sv
module dchain_cmd_dec
    import dchain_pkg::*;
(
    input  logic [WORD_W-1:0] cmd_word,
    output dc_cmd_t           cmd
);
    logic [1:0] burst_code;
    logic [1:0] width_code;
    logic       unused_cmd_bits;

    assign burst_code = cmd_word[CB_BURST_LO +: 2];
    assign width_code = cmd_word[CB_WIDTH_LO +: 2];
    assign unused_cmd_bits = ^{cmd_word[27:23], cmd_word[20:18], cmd_word[13]};

    always_comb begin
        cmd.src_inc   = cmd_word[CB_SRC_INC];
        cmd.dst_inc   = cmd_word[CB_DST_INC];
        cmd.paced     = cmd_word[CB_PACE_SRC] | cmd_word[CB_PACE_DST];
        cmd.irq_start = cmd_word[CB_IRQ_START];
        cmd.irq_end   = cmd_word[CB_IRQ_END];
        cmd.len       = cmd_word[LEN_W-1:0];
        unique case (burst_code)
            2'd2:    cmd.burst_bytes = BURST_W'(16);
            2'd3:    cmd.burst_bytes = BURST_W'(32);
            default: cmd.burst_bytes = BURST_W'(8);
        endcase
        unique case (width_code)
            2'd1:    cmd.width_bytes = BEAT_W'(1);
            2'd2:    cmd.width_bytes = BEAT_W'(2);
            default: cmd.width_bytes = BEAT_W'(4);
        endcase
    end
endmodule

// File: rtl/dchain_xfer_ctr.sv
module dchain_xfer_ctr
    import dchain_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [WORD_W-1:0]  src_in,
    input  logic [WORD_W-1:0]  dst_in,
    input  dc_cmd_t            cmd,
    input  logic               burst_start,
    input  logic               rd_step,
    input  logic               wr_step,
    output logic [WORD_W-1:0]  src_addr,
    output logic [WORD_W-1:0]  dst_addr,
    output logic [BEAT_W-1:0]  rd_bytes,
    output logic [BEAT_W-1:0]  wr_bytes,
    output logic               rd_last,
    output logic               wr_last,
    output logic               final_burst
);
    logic [LEN_W-1:0]   remain_q;
    logic [BURST_W-1:0] blen_q, rd_off_q, wr_off_q;
    logic [BURST_W-1:0] blen_n, rd_left, wr_left;

    always_comb begin
        blen_n  = ({{(LEN_W-BURST_W){1'b0}}, cmd.burst_bytes} > remain_q)
                  ? remain_q[BURST_W-1:0] : cmd.burst_bytes;
        rd_left = blen_q - rd_off_q;
        wr_left = blen_q - wr_off_q;
        rd_bytes = ({{(BURST_W-BEAT_W){1'b0}}, cmd.width_bytes} > rd_left)
                   ? rd_left[BEAT_W-1:0] : cmd.width_bytes;
        wr_bytes = ({{(BURST_W-BEAT_W){1'b0}}, cmd.width_bytes} > wr_left)
                   ? wr_left[BEAT_W-1:0] : cmd.width_bytes;
        rd_last = (rd_off_q + {{(BURST_W-BEAT_W){1'b0}}, rd_bytes}) == blen_q;
        wr_last = (wr_off_q + {{(BURST_W-BEAT_W){1'b0}}, wr_bytes}) == blen_q;
        final_burst = remain_q == {{(LEN_W-BURST_W){1'b0}}, blen_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
            remain_q <= '0;
            blen_q   <= '0;
            rd_off_q <= '0;
            wr_off_q <= '0;
        end else if (load) begin
            src_addr <= src_in;
            dst_addr <= dst_in;
            remain_q <= cmd.len;
            blen_q   <= '0;
            rd_off_q <= '0;
            wr_off_q <= '0;
        end else begin
            if (burst_start) begin
                blen_q   <= blen_n;
                rd_off_q <= '0;
                wr_off_q <= '0;
            end
            if (rd_step) begin
                rd_off_q <= rd_off_q + {{(BURST_W-BEAT_W){1'b0}}, rd_bytes};
                if (cmd.src_inc)
                    src_addr <= src_addr + {{(WORD_W-BEAT_W){1'b0}}, rd_bytes};
            end
            if (wr_step) begin
                wr_off_q <= wr_off_q + {{(BURST_W-BEAT_W){1'b0}}, wr_bytes};
                if (cmd.dst_inc)
                    dst_addr <= dst_addr + {{(WORD_W-BEAT_W){1'b0}}, wr_bytes};
                if (wr_last)
                    remain_q <= remain_q - {{(LEN_W-BURST_W){1'b0}}, blen_q};
            end
        end
    end

    // R4: reads never run past the burst length held for this burst
    assert_burst_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_step |=> (rd_off_q <= blen_q));

    // R4: writes never overtake reads within a burst
    assert_write_behind_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_step |-> (wr_off_q < rd_off_q));
endmodule

// File: rtl/dchain_burst_buf.sv
module dchain_burst_buf #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW:0]       wcnt_q, rcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else if (clr) begin
            wcnt_q <= '0;
            rcnt_q <= '0;
        end else begin
            if (push) wcnt_q <= wcnt_q + 1'b1;
            if (pop)  rcnt_q <= rcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push && !clr)
            store[wcnt_q[AW-1:0]] <= din;
    end

    assign dout = store[rcnt_q[AW-1:0]];

    // R4: a burst never holds more beats than the buffer has entries
    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (wcnt_q < (AW+1)'(DEPTH)));

    // R4: a beat is written out only after it was read in
    assert_pop_filled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (rcnt_q < wcnt_q));
endmodule

// File: rtl/dchain_seq.sv
module dchain_seq
    import dchain_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_go,
    input  logic [31:0]       ctl_desc_ptr,
    input  logic              ctl_halt,
    input  logic              dev_req,
    output logic              dsc_req,
    output logic [31:0]       dsc_addr,
    input  logic              dsc_ack,
    input  logic              dsc_err,
    input  logic [31:0]       dsc_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [2:0]        mem_bytes,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    input  logic [31:0]       mem_rdata,
    output logic              sts_halted,
    output logic              sts_end,
    output logic              sts_start,
    output logic              sts_buserr
);
    localparam int DW = WORD_W;

    dc_state_e        state_q, state_n;
    logic [1:0]       wd_idx_q;
    logic [DW-1:0]    dsc_ptr_q, link_q, src_q, dst_q, cmd_q;
    logic             halt_pend_q, halt_now;
    logic             end_q, start_q, buserr_q;
    dc_cmd_t          cmd;
    logic [DW-1:0]    x_src, x_dst, buf_dout;
    logic [BEAT_W-1:0] rd_bytes, wr_bytes;
    logic             rd_last, wr_last, final_burst;
    logic             rd_step, wr_step, burst_start, ctr_load;
    logic             unused_ptr_bits;

    assign unused_ptr_bits = ^{ctl_desc_ptr[3:0], link_q[3:1]};
    assign halt_now = halt_pend_q | ctl_halt;

    dchain_cmd_dec u_dec (
        .cmd_word (cmd_q),
        .cmd      (cmd)
    );

    dchain_xfer_ctr u_ctr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ctr_load),
        .src_in      (src_q),
        .dst_in      (dst_q),
        .cmd         (cmd),
        .burst_start (burst_start),
        .rd_step     (rd_step),
        .wr_step     (wr_step),
        .src_addr    (x_src),
        .dst_addr    (x_dst),
        .rd_bytes    (rd_bytes),
        .wr_bytes    (wr_bytes),
        .rd_last     (rd_last),
        .wr_last     (wr_last),
        .final_burst (final_burst)
    );

    dchain_burst_buf #(.DATA_W(DW), .DEPTH(BUF_DEPTH)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (burst_start),
        .push  (rd_step),
        .pop   (wr_step),
        .din   (mem_rdata),
        .dout  (buf_dout)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (ctl_go) state_n = ST_FETCH;
            ST_FETCH:  if (dsc_ack) begin
                           if (dsc_err || halt_now)  state_n = ST_IDLE;
                           else if (wd_idx_q == 2'd3) state_n = ST_DECODE;
                       end
            ST_DECODE: if (halt_now)           state_n = ST_IDLE;
                       else if (cmd.len == '0) state_n = ST_RETIRE;
                       else                    state_n = ST_PACE;
            ST_PACE:   if (halt_now)                   state_n = ST_IDLE;
                       else if (!cmd.paced || dev_req) state_n = ST_READ;
            ST_READ:   if (mem_ack) begin
                           if (mem_err || halt_now) state_n = ST_IDLE;
                           else if (rd_last)        state_n = ST_WRITE;
                       end
            ST_WRITE:  if (mem_ack) begin
                           if (mem_err || halt_now) state_n = ST_IDLE;
                           else if (wr_last)        state_n = final_burst ? ST_RETIRE : ST_PACE;
                       end
            ST_RETIRE: if (link_q[0] || halt_now) state_n = ST_IDLE;
                       else                       state_n = ST_FETCH;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // outputs and datapath strobes
    always_comb begin
        dsc_req     = (state_q == ST_FETCH);
        dsc_addr    = dsc_ptr_q + {{(DW-4){1'b0}}, wd_idx_q, 2'b00};
        mem_req     = (state_q == ST_READ) || (state_q == ST_WRITE);
        mem_we      = (state_q == ST_WRITE);
        mem_addr    = mem_we ? x_dst : x_src;
        mem_bytes   = mem_we ? wr_bytes : rd_bytes;
        mem_wdata   = buf_dout;
        sts_halted  = (state_q == ST_IDLE);
        sts_end     = end_q;
        sts_start   = start_q;
        sts_buserr  = buserr_q;
        ctr_load    = (state_q == ST_DECODE);
        burst_start = (state_q == ST_PACE) && (state_n == ST_READ);
        rd_step     = (state_q == ST_READ)  && mem_ack && !mem_err;
        wr_step     = (state_q == ST_WRITE) && mem_ack && !mem_err;
    end

    // descriptor registers and status flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wd_idx_q    <= '0;
            dsc_ptr_q   <= '0;
            link_q      <= '0;
            src_q       <= '0;
            dst_q       <= '0;
            cmd_q       <= '0;
            halt_pend_q <= 1'b0;
            end_q       <= 1'b0;
            start_q     <= 1'b0;
            buserr_q    <= 1'b0;
        end else begin
            if (state_q != ST_IDLE && state_n == ST_IDLE)
                halt_pend_q <= 1'b0;
            else if (state_q != ST_IDLE && ctl_halt)
                halt_pend_q <= 1'b1;

            if (state_q == ST_IDLE && ctl_go) begin
                dsc_ptr_q <= {ctl_desc_ptr[DW-1:4], 4'b0000};
                wd_idx_q  <= '0;
                end_q     <= 1'b0;
                start_q   <= 1'b0;
                buserr_q  <= 1'b0;
            end
            if (state_q == ST_FETCH && dsc_ack) begin
                if (dsc_err) begin
                    buserr_q <= 1'b1;
                end else begin
                    unique case (wd_idx_q)
                        2'd0:    link_q <= dsc_rdata;
                        2'd1:    src_q  <= dsc_rdata;
                        2'd2:    dst_q  <= dsc_rdata;
                        default: cmd_q  <= dsc_rdata;
                    endcase
                    wd_idx_q <= wd_idx_q + 2'd1;
                end
            end
            if (state_q == ST_DECODE && cmd.irq_start)
                start_q <= 1'b1;
            if ((state_q == ST_READ || state_q == ST_WRITE) && mem_ack && mem_err)
                buserr_q <= 1'b1;
            if (state_q == ST_RETIRE) begin
                if (cmd.irq_end) end_q <= 1'b1;
                dsc_ptr_q <= {link_q[DW-1:4], 4'b0000};
                wd_idx_q  <= '0;
            end
        end
    end

    // R2: fetch and data ports never request together
    assert_one_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dsc_req && mem_req));

    // R2: a fetch request holds its address until acknowledged
    assert_dsc_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dsc_req && !dsc_ack) |=> (dsc_req && $stable(dsc_addr)));

    // R3: a data beat holds address and direction until acknowledged
    assert_mem_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5: every beat carries one to four bytes
    assert_beat_size_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_bytes != 3'd0 && mem_bytes <= 3'd4));

    // R10: a paced burst does not begin without the peripheral request
    assert_paced_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PACE && cmd.paced && !dev_req) |=> !mem_req);

    // R12: a data error halts the channel with the error flag raised
    assert_err_stop_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (sts_halted && sts_buserr));
endmodule

// File: tb/dchain_seq_tb_top.sv
module dchain_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_go = 1'b0, ctl_halt = 1'b0, dev_req = 1'b0;
    logic [31:0] ctl_desc_ptr = '0;
    logic        dsc_req, dsc_ack = 1'b0, dsc_err = 1'b0;
    logic [31:0] dsc_addr, dsc_rdata = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [2:0]  mem_bytes;
    logic        sts_halted, sts_end, sts_start, sts_buserr;

    int n_vec = 0, n_bad = 0;
    bit finished = 0;

    logic [7:0]  mem [0:4095];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [31:0] fetch_log [0:63];
    int n_fetch = 0, n_wr_bytes = 0, run_cnt = 0, n_runs = 0;
    int runs [0:63];

    always #4 clk = ~clk;

    dchain_seq dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_go(ctl_go), .ctl_desc_ptr(ctl_desc_ptr),
        .ctl_halt(ctl_halt), .dev_req(dev_req),
        .dsc_req(dsc_req), .dsc_addr(dsc_addr), .dsc_ack(dsc_ack), .dsc_err(dsc_err),
        .dsc_rdata(dsc_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_bytes(mem_bytes),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err), .mem_rdata(mem_rdata),
        .sts_halted(sts_halted), .sts_end(sts_end), .sts_start(sts_start),
        .sts_buserr(sts_buserr)
    );

    function automatic logic [31:0] rd32(input logic [31:0] a);
        return {mem[(a+3) & 32'hFFF], mem[(a+2) & 32'hFFF],
                mem[(a+1) & 32'hFFF], mem[a & 32'hFFF]};
    endfunction

    task automatic wr32(input logic [31:0] a, input logic [31:0] d);
        for (int i = 0; i < 4; i++) mem[(a+i) & 32'hFFF] = d[8*i +: 8];
    endtask

    // memory model: acknowledges every request one edge later
    always @(negedge clk) begin
        dsc_ack = 1'b0; dsc_err = 1'b0; mem_ack = 1'b0; mem_err = 1'b0;
        if (dsc_req) begin
            dsc_ack   = 1'b1;
            dsc_err   = (dsc_addr == err_addr);
            dsc_rdata = rd32(dsc_addr);
            if (n_fetch < 64) fetch_log[n_fetch] = dsc_addr;
            n_fetch++;
        end
        if (mem_req) begin
            mem_ack = 1'b1;
            mem_err = (mem_addr == err_addr);
            if (!mem_we) begin
                mem_rdata = rd32(mem_addr);
                run_cnt++;
            end else begin
                if (!mem_err)
                    for (int i = 0; i < 4; i++)
                        if (i < int'(mem_bytes)) mem[(mem_addr+i) & 32'hFFF] = mem_wdata[8*i +: 8];
                n_wr_bytes += int'(mem_bytes);
                if (run_cnt != 0) begin
                    if (n_runs < 64) runs[n_runs] = run_cnt;
                    n_runs++;
                    run_cnt = 0;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(input bit si, input bit di, input bit pace,
                                           input bit st, input bit en, input int burst,
                                           input int width, input int len);
        logic [31:0] c = '0;
        c[31] = si; c[30] = di; c[29] = pace; c[22] = st; c[21] = en;
        c[17:16] = burst[1:0]; c[15:14] = width[1:0]; c[12:0] = len[12:0];
        return c;
    endfunction

    task automatic put_desc(input logic [31:0] a, input logic [31:0] link,
                            input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
        wr32(a, link); wr32(a+4, s); wr32(a+8, d); wr32(a+12, c);
    endtask

    task automatic prep(input logic [31:0] s, input logic [31:0] d, input int n, input int seed);
        for (int i = 0; i < n; i++) mem[(s+i) & 32'hFFF] = 8'((seed*7 + i*13 + 1) & 8'hFF);
        for (int i = 0; i < n + 8; i++) mem[(d+i) & 32'hFFF] = 8'hEE;
    endtask

    function automatic int same(input logic [31:0] s, input logic [31:0] d, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) if (mem[(s+i) & 32'hFFF] !== mem[(d+i) & 32'hFFF]) bad++;
        return bad;
    endfunction

    task automatic clear_logs();
        n_fetch = 0; n_wr_bytes = 0; run_cnt = 0; n_runs = 0; err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic go(input logic [31:0] ptr);
        @(negedge clk);
        ctl_desc_ptr = ptr; ctl_go = 1'b1;
        @(negedge clk);
        ctl_go = 1'b0;
    endtask

    task automatic wait_halt();
        for (int i = 0; i < 5000; i++) begin
            if (sts_halted) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(sts_halted === 1'b1, "R1 halted", int'(sts_halted), 1);
        chk({sts_end, sts_start, sts_buserr} === 3'b000, "R1 flags",
            int'({sts_end, sts_start, sts_buserr}), 0);
        chk(!dsc_req && !mem_req, "R1 requests", int'({dsc_req, mem_req}), 0);
    endtask

    task automatic t_basic();
        clear_logs();
        prep(32'h400, 32'h800, 40, 1);
        put_desc(32'h100, 32'h1, 32'h400, 32'h800, mk_cmd(1, 1, 0, 0, 1, 2, 3, 40));
        dev_req = 1'b0;   // ignored when unpaced (R10)
        go(32'h103);      // low bits dropped (R2)
        wait_halt();
        chk(n_fetch == 4 && fetch_log[0] == 32'h100 && fetch_log[1] == 32'h104 &&
            fetch_log[2] == 32'h108 && fetch_log[3] == 32'h10C, "R2 fetch order",
            int'(fetch_log[3]), 32'h10C);
        chk(same(32'h400, 32'h800, 40) == 0 && n_wr_bytes == 40, "R3 copy length",
            n_wr_bytes, 40);
        chk(n_runs == 3 && runs[0] == 4 && runs[1] == 4 && runs[2] == 2, "R4 burst runs",
            runs[2], 2);
        chk(sts_end === 1'b1 && sts_start === 1'b0, "R8 end set", int'(sts_end), 1);
        chk(sts_halted === 1'b1 && mem[32'h828] === 8'hEE, "R6 stop halts",
            int'(sts_halted), 1);
        chk(n_wr_bytes == 40, "R10 unpaced ignores dev_req", n_wr_bytes, 40);
    endtask

    task automatic t_width1();
        clear_logs();
        prep(32'h410, 32'h820, 5, 2);
        put_desc(32'h100, 32'h1, 32'h410, 32'h820, mk_cmd(1, 1, 0, 0, 0, 0, 1, 5));
        go(32'h100);
        wait_halt();
        chk(same(32'h410, 32'h820, 5) == 0 && mem[32'h825] === 8'hEE, "R5 byte width",
            same(32'h410, 32'h820, 5), 0);
        chk(n_runs == 1 && runs[0] == 5, "R4 default burst 8", runs[0], 5);
    endtask

    task automatic t_width2();
        clear_logs();
        prep(32'h420, 32'h840, 7, 3);
        put_desc(32'h100, 32'h1, 32'h420, 32'h840, mk_cmd(1, 1, 0, 0, 0, 1, 2, 7));
        go(32'h100);
        wait_halt();
        chk(same(32'h420, 32'h840, 7) == 0 && mem[32'h847] === 8'hEE && n_wr_bytes == 7,
            "R5 half width tail", n_wr_bytes, 7);
        chk(n_runs == 1 && runs[0] == 4, "R4 short final burst", runs[0], 4);
    endtask

    task automatic t_chain();
        clear_logs();
        prep(32'h430, 32'h860, 8, 4);
        prep(32'h440, 32'h880, 12, 5);
        put_desc(32'h140, 32'h180, 32'h430, 32'h860, mk_cmd(1, 1, 0, 0, 0, 3, 3, 8));
        put_desc(32'h180, 32'h1C0, 32'h600, 32'h700, mk_cmd(1, 1, 0, 0, 0, 3, 3, 0));
        put_desc(32'h1C0, 32'h1, 32'h440, 32'h880, mk_cmd(1, 1, 0, 0, 1, 3, 3, 12));
        go(32'h140);
        wait_halt();
        chk(n_fetch == 12 && fetch_log[4] == 32'h180 && fetch_log[8] == 32'h1C0,
            "R6 link follow", n_fetch, 12);
        chk(n_wr_bytes == 20 && same(32'h430, 32'h860, 8) == 0 && same(32'h440, 32'h880, 12) == 0,
            "R7 zero length", n_wr_bytes, 20);
    endtask

    task automatic t_flags();
        clear_logs();
        prep(32'h450, 32'h8A0, 8, 6);
        put_desc(32'h100, 32'h1, 32'h450, 32'h8A0, mk_cmd(1, 1, 0, 1, 0, 1, 3, 8));
        go(32'h100);
        wait_halt();
        chk(sts_end === 1'b0, "R8 no end without bit", int'(sts_end), 0);
        chk(sts_start === 1'b1, "R9 start flag", int'(sts_start), 1);
    endtask

    task automatic t_fixed_dst();
        clear_logs();
        prep(32'h460, 32'h8C0, 12, 7);
        put_desc(32'h100, 32'h1, 32'h460, 32'h8C0, mk_cmd(1, 0, 0, 0, 0, 2, 3, 12));
        go(32'h100);
        wait_halt();
        chk(rd32(32'h8C0) == rd32(32'h468) && mem[32'h8C4] === 8'hEE, "R3 fixed target",
            int'(rd32(32'h8C0)), int'(rd32(32'h468)));
    endtask

    task automatic t_pace();
        clear_logs();
        prep(32'h470, 32'h8E0, 16, 8);
        put_desc(32'h100, 32'h1, 32'h470, 32'h8E0, mk_cmd(1, 1, 1, 0, 0, 1, 3, 16));
        dev_req = 1'b0;
        go(32'h100);
        repeat (30) @(negedge clk);
        chk(n_wr_bytes == 0 && sts_halted === 1'b0, "R10 paced waits", n_wr_bytes, 0);
        dev_req = 1'b1;
        wait_halt();
        dev_req = 1'b0;
        chk(same(32'h470, 32'h8E0, 16) == 0, "R10 paced completes", same(32'h470, 32'h8E0, 16), 0);
    endtask

    task automatic t_halt();
        int snap;
        clear_logs();
        prep(32'h500, 32'hA00, 256, 9);
        put_desc(32'h100, 32'h1, 32'h500, 32'hA00, mk_cmd(1, 1, 0, 0, 1, 1, 1, 256));
        go(32'h100);
        repeat (40) @(negedge clk);
        ctl_halt = 1'b1;
        @(negedge clk);
        ctl_halt = 1'b0;
        repeat (3) @(negedge clk);
        snap = n_wr_bytes;
        repeat (20) @(negedge clk);
        chk(sts_halted === 1'b1 && n_wr_bytes == snap && snap < 256 && sts_end === 1'b0,
            "R11 halt stops", n_wr_bytes, snap);
    endtask

    task automatic t_err_data();
        clear_logs();
        prep(32'h480, 32'h900, 16, 10);
        put_desc(32'h100, 32'h140, 32'h480, 32'h900, mk_cmd(1, 1, 0, 0, 1, 1, 3, 16));
        put_desc(32'h140, 32'h1, 32'h480, 32'h940, mk_cmd(1, 1, 0, 0, 1, 1, 3, 16));
        err_addr = 32'h488;
        go(32'h100);
        wait_halt();
        chk(sts_buserr === 1'b1 && n_fetch == 4 && sts_end === 1'b0, "R12 data error",
            n_fetch, 4);
    endtask

    task automatic t_err_fetch();
        clear_logs();
        put_desc(32'h200, 32'h1, 32'h480, 32'h900, mk_cmd(1, 1, 0, 0, 1, 1, 3, 16));
        err_addr = 32'h208;
        go(32'h200);
        wait_halt();
        chk(sts_buserr === 1'b1 && n_wr_bytes == 0 && n_fetch == 3, "R12 fetch error",
            n_fetch, 3);
    endtask

    task automatic t_go_clears();
        clear_logs();
        prep(32'h4C0, 32'h980, 8, 11);
        put_desc(32'h100, 32'h1, 32'h4C0, 32'h980, mk_cmd(1, 1, 0, 0, 0, 1, 3, 8));
        go(32'h100);
        wait_halt();
        chk({sts_buserr, sts_end, sts_start} === 3'b000, "R13 start clears",
            int'({sts_buserr, sts_end, sts_start}), 0);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_width1();
        t_width2();
        t_chain();
        t_flags();
        t_fixed_dst();
        t_pace();
        t_halt();
        t_err_data();
        t_err_fetch();
        t_go_clears();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule